// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests for a small 8-bit processor with a 16-bit address space. It has five request lines. Line 0 carries the vertical-blank pulse from the display engine. Each request latches a bit in a flag register. A separate enable register selects which sources may interrupt the processor. Software reads and writes both registers over a byte-wide bus whose reads are combinational. A global master enable gates all servicing. The processor sets and clears it with single-cycle strobes, which stand in for its enable, disable and return-from-interrupt instructions.

The processor pulses a step strobe at each instruction boundary, before it fetches the next opcode. If the master enable is on and some source is both flagged and enabled, the block picks the lowest-numbered such source. On the next cycle it raises a one-cycle dispatch strobe with that source's restart address. In the same clock edge it clears only that source's flag and drops the master enable. Other pending flags stay set and are serviced at later steps, once the master enable is turned back on.

Top module: `irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, the flag register reads 0xE0, the master enable is 0 and no dispatch is signalled.
- R2: The enable register is at address 0xFFFF. All 8 bits can be written and read back unchanged.
- R3: The flag register is at address 0xFF0F. Bits 4..0 can be written and read back. Bits 7..5 always read as 1 and ignore writes.
- R4: A one-cycle high on request line i (line 0 is vertical blank) sets flag bit i at the next clock edge. The other flag bits are left unchanged.
- R5: If a request and a bus write to the flag register happen in the same cycle, the request bit is ORed on top of the written value.
- R6: A step produces no dispatch when the master enable is 0, or when the AND of the enable register and the flag register (bits 4..0) is zero. In that case the flags and the master enable are left unchanged.
- R7: When several sources are pending, the lowest-numbered one is serviced. Only one source is serviced per step.
- R8: A dispatch appears as a one-cycle pulse on dispatch_o in the cycle after the step. vector_o then carries 0x0040 + 8*i, that is 0x40, 0x48, 0x50, 0x58 or 0x60 for sources 0 to 4.
- R9: A dispatch clears the master enable and only the serviced flag bit. All other flag bits keep their value.
- R10: The master-enable set strobe turns the master enable on at the next edge. The clear strobe turns it off and wins over a same-cycle set. A dispatch wins over a same-cycle set.
- R11: Other addresses do not hit: bus_hit_o is 0, bus_rdata_o is 0x00, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 16 | Bus address |
| bus_wdata_i | input | 8 | Bus write data |
| bus_we_i | input | 1 | Bus write strobe |
| bus_rdata_o | output | 8 | Combinational read data |
| bus_hit_o | output | 1 | Address selects one of the two registers |
| req_i | input | 5 | Request pulses, bit 0 is vertical blank |
| step_i | input | 1 | Instruction boundary strobe |
| ime_set_i | input | 1 | Master enable set strobe |
| ime_clr_i | input | 1 | Master enable clear strobe |
| ime_o | output | 1 | Current master enable |
| dispatch_o | output | 1 | One-cycle dispatch pulse |
| vector_o | output | 16 | Restart address of the last dispatch |

## Verification
The bench runs the dispatch path with several pending patterns:
- Single flags walked through all five sources, which tells the five vector addresses apart.
- Two flags pending at once, which shows that the lower bit wins and the higher one survives for a later step.
- A flag set while its enable is clear, which shows that masking happens before priority.
- Steps with the master enable off, or with nothing pending, which show the gating.

Same-cycle collisions are driven on purpose: a request together with a flag write, a set together with a clear, and a set together with a dispatching step. These separate the stated orderings from their reversals.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_SRC  = 5;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned DATA_W   = 8;
  localparam logic [15:0] ENA_ADDR = 16'hFFFF;
  localparam logic [15:0] FLG_ADDR = 16'hFF0F;
  localparam logic [15:0] VEC_BASE = 16'h0040;
  localparam int unsigned VEC_STEP = 8;
endpackage

// File: rtl/irq_regs.sv
module irq_regs #(
  parameter int unsigned NSRC = irq_pkg::NUM_SRC,
  parameter int unsigned AW   = irq_pkg::ADDR_W,
  parameter int unsigned DW   = irq_pkg::DATA_W,
  parameter logic [AW-1:0] EADDR = irq_pkg::ENA_ADDR,
  parameter logic [AW-1:0] FADDR = irq_pkg::FLG_ADDR
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            we_i,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] svc_clr_i,
  output logic [DW-1:0]   rdata_o,
  output logic            hit_o,
  output logic [DW-1:0]   ena_o,
  output logic [NSRC-1:0] flag_o
);
  localparam int unsigned PAD = DW - NSRC;

  logic [DW-1:0]   ena_q;
  logic [NSRC-1:0] flag_q, flag_d;
  logic            sel_ena, sel_flg;
  logic            unused_wbits;

  assign sel_ena = (addr_i == EADDR);
  assign sel_flg = (addr_i == FADDR);
  assign unused_wbits = ^wdata_i[DW-1:NSRC];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ena_q <= '0;
    else if (we_i && sel_ena) ena_q <= wdata_i;
  end

  // order: bus write, then service clear, then hardware requests
  always_comb begin
    flag_d = flag_q;
    if (we_i && sel_flg) flag_d = wdata_i[NSRC-1:0];
    flag_d = flag_d & ~svc_clr_i;
    flag_d = flag_d | req_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ena)      rdata_o = ena_q;
    else if (sel_flg) rdata_o = {{PAD{1'b1}}, flag_q};
  end

  assign hit_o  = sel_ena | sel_flg;
  assign ena_o  = ena_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned NSRC = irq_pkg::NUM_SRC,
  localparam int unsigned IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] pend_i,
  output logic            any_o,
  output logic [NSRC-1:0] grant_o,
  output logic [IW-1:0]   idx_o
);
  logic [NSRC-1:0] seen;

  for (genvar g = 0; g < NSRC; g++) begin : g_chain
    if (g == 0) begin : g_first
      assign grant_o[g] = pend_i[g];
      assign seen[g]    = pend_i[g];
    end else begin : g_rest
      assign grant_o[g] = pend_i[g] & ~seen[g-1];
      assign seen[g]    = seen[g-1] | pend_i[g];
    end
  end

  assign any_o = seen[NSRC-1];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant_o[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq #(
  parameter int unsigned NSRC = irq_pkg::NUM_SRC,
  parameter int unsigned AW   = irq_pkg::ADDR_W,
  parameter logic [AW-1:0] VBASE = irq_pkg::VEC_BASE,
  parameter int unsigned VSTEP = irq_pkg::VEC_STEP,
  localparam int unsigned IW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic            set_i,
  input  logic            clr_i,
  input  logic            any_i,
  input  logic [NSRC-1:0] grant_i,
  input  logic [IW-1:0]   idx_i,
  output logic [NSRC-1:0] svc_clr_o,
  output logic            ime_o,
  output logic            disp_o,
  output logic [AW-1:0]   vec_o
);
  logic ime_q, go;
  logic disp_q;
  logic [AW-1:0] vec_q;

  assign go        = step_i & ime_q & any_i;
  assign svc_clr_o = go ? grant_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ime_q <= 1'b0;
    else if (go)    ime_q <= 1'b0;
    else if (clr_i) ime_q <= 1'b0;
    else if (set_i) ime_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      disp_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      disp_q <= go;
      if (go) vec_q <= VBASE + AW'(VSTEP) * AW'(idx_i);
    end
  end

  assign ime_o  = ime_q;
  assign disp_o = disp_q;
  assign vec_o  = vec_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_we_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_hit_o,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic              step_i,
  input  logic              ime_set_i,
  input  logic              ime_clr_i,
  output logic              ime_o,
  output logic              dispatch_o,
  output logic [ADDR_W-1:0] vector_o
);
  localparam int unsigned IW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [DATA_W-1:0]  ena_w;
  logic [NUM_SRC-1:0] flag_w, pend_w, grant_w, clr_w;
  logic [IW-1:0]      idx_w;
  logic               any_w;
  logic               unused_ena;

  irq_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .we_i      (bus_we_i),
    .req_i     (req_i),
    .svc_clr_i (clr_w),
    .rdata_o   (bus_rdata_o),
    .hit_o     (bus_hit_o),
    .ena_o     (ena_w),
    .flag_o    (flag_w)
  );

  assign pend_w     = ena_w[NUM_SRC-1:0] & flag_w;
  assign unused_ena = ^ena_w[DATA_W-1:NUM_SRC];

  irq_pick u_pick (
    .pend_i  (pend_w),
    .any_o   (any_w),
    .grant_o (grant_w),
    .idx_o   (idx_w)
  );

  irq_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step_i),
    .set_i     (ime_set_i),
    .clr_i     (ime_clr_i),
    .any_i     (any_w),
    .grant_i   (grant_w),
    .idx_i     (idx_w),
    .svc_clr_o (clr_w),
    .ime_o     (ime_o),
    .disp_o    (dispatch_o),
    .vec_o     (vector_o)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] bus_addr_i,
  input logic [7:0]  bus_rdata_o,
  input logic [4:0]  req_i,
  input logic        step_i,
  input logic        ime_set_i,
  input logic        ime_clr_i,
  input logic        ime_o,
  input logic        dispatch_o,
  input logic [15:0] vector_o,
  input logic [4:0]  flag_w
);
  a_r3_high_bits_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i == 16'hFF0F) |-> (bus_rdata_o[7:5] == 3'b111));

  a_r4_req_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i != 5'd0) |=> ((flag_w & $past(req_i)) == $past(req_i)));

  a_r6_no_dispatch_ime_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !ime_o) |=> !dispatch_o);

  a_r8_dispatch_follows_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dispatch_o) |-> $past(step_i));

  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispatch_o |=> !dispatch_o);

  a_r8_vector_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispatch_o |-> (vector_o == 16'h0040 || vector_o == 16'h0048 ||
                    vector_o == 16'h0050 || vector_o == 16'h0058 ||
                    vector_o == 16'h0060));

  a_r9_ime_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dispatch_o |-> !ime_o);

  a_r10_clr_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ime_clr_i |=> !ime_o);

  a_r10_set_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ime_set_i && !ime_clr_i && !step_i) |=> ime_o);
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (.*);

// File: tb/tb_irq_ctrl.sv
`timescale 1ns/1ps
module tb_irq_ctrl;
  localparam int K_RD = 0, K_HIT = 1, K_DISP = 2, K_NODISP = 3, K_IME = 4;

  typedef struct {
    int          cyc;
    int          kind;
    logic [15:0] val;
    string       tag;
  } exp_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] bus_addr_i = '0;
  logic [7:0]  bus_wdata_i = '0;
  logic        bus_we_i = 1'b0;
  logic [7:0]  bus_rdata_o;
  logic        bus_hit_o;
  logic [4:0]  req_i = '0;
  logic        step_i = 1'b0;
  logic        ime_set_i = 1'b0;
  logic        ime_clr_i = 1'b0;
  logic        ime_o;
  logic        dispatch_o;
  logic [15:0] vector_o;

  int   cyc = 0;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 1'b0;
  exp_t q[$];

  irq_ctrl dut (.*);

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: compare every expected item due in the current cycle
  always @(negedge clk_i) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      logic [15:0] act;
      bit ok;
      e = q.pop_front();
      n_run++;
      ok = 1'b0;
      act = '0;
      case (e.kind)
        K_RD:     begin act = {8'h00, bus_rdata_o}; ok = (act == e.val); end
        K_HIT:    begin act = {15'd0, bus_hit_o};   ok = (act == e.val); end
        K_DISP:   begin act = dispatch_o ? vector_o : 16'hDEAD; ok = (act == e.val); end
        K_NODISP: begin act = {15'd0, dispatch_o};  ok = (dispatch_o == 1'b0); end
        default:  begin act = {15'd0, ime_o};       ok = (act == e.val); end
      endcase
      if (e.cyc != cyc) ok = 1'b0;
      if (!ok) begin
        n_fail++;
        $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", e.tag, act, e.val, cyc);
      end
    end
  end

  task automatic push(int c, int k, logic [15:0] v, string t);
    exp_t e;
    e.cyc = c; e.kind = k; e.val = v; e.tag = t;
    q.push_back(e);
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
    bus_we_i = 1'b0; req_i = '0; step_i = 1'b0;
    ime_set_i = 1'b0; ime_clr_i = 1'b0;
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    tick();
  endtask

  task automatic rd_chk(logic [15:0] a, logic [7:0] exp, logic hit, string t);
    bus_addr_i = a;
    push(cyc, K_RD, {8'h00, exp}, t);
    push(cyc, K_HIT, {15'd0, hit}, t);
    tick();
  endtask

  task automatic ime_chk(logic exp, string t);
    push(cyc, K_IME, {15'd0, exp}, t);
    tick();
  endtask

  task automatic step_chk(bit expect_disp, logic [15:0] vec, string t);
    step_i = 1'b1;
    if (expect_disp) push(cyc + 1, K_DISP, vec, t);
    else             push(cyc + 1, K_NODISP, 16'd0, t);
    tick();
  endtask

  task automatic set_ime();
    ime_set_i = 1'b1;
    tick();
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    tick();

    // R1 reset state
    rd_chk(16'hFFFF, 8'h00, 1'b1, "R1 enable after reset");
    rd_chk(16'hFF0F, 8'hE0, 1'b1, "R1 flags after reset");
    push(cyc, K_NODISP, 16'd0, "R1 no dispatch after reset");
    ime_chk(1'b0, "R1 ime after reset");

    // R2 enable readback
    wr(16'hFFFF, 8'hA5);
    rd_chk(16'hFFFF, 8'hA5, 1'b1, "R2 enable readback A5");
    wr(16'hFFFF, 8'h1F);
    rd_chk(16'hFFFF, 8'h1F, 1'b1, "R2 enable readback 1F");

    // R3 flag register write and fixed high bits
    wr(16'hFF0F, 8'hFF);
    rd_chk(16'hFF0F, 8'hFF, 1'b1, "R3 flags all set");
    wr(16'hFF0F, 8'h0A);
    rd_chk(16'hFF0F, 8'hEA, 1'b1, "R3 flags 0A high bits one");
    wr(16'hFF0F, 8'hE0);
    rd_chk(16'hFF0F, 8'hE0, 1'b1, "R3 high bit writes ignored");

    // R11 unmapped addresses
    rd_chk(16'hFF0E, 8'h00, 1'b0, "R11 unmapped read");
    wr(16'h1234, 8'hFF);
    wr(16'hFFFE, 8'hFF);
    rd_chk(16'hFFFF, 8'h1F, 1'b1, "R11 enable untouched");
    rd_chk(16'hFF0F, 8'hE0, 1'b1, "R11 flags untouched");

    // R4 request pulses, line 0 is vertical blank
    req_i = 5'b00001; tick();
    rd_chk(16'hFF0F, 8'hE1, 1'b1, "R4 vblank sets bit 0");
    req_i = 5'b00100; tick();
    rd_chk(16'hFF0F, 8'hE5, 1'b1, "R4 bit 2 set, bit 0 kept");

    // R6 master enable off blocks dispatch
    step_chk(1'b0, 16'h0, "R6 no dispatch with ime off");
    rd_chk(16'hFF0F, 8'hE5, 1'b1, "R6 flags unchanged");

    // R10 master enable strobes
    set_ime();
    ime_chk(1'b1, "R10 set strobe");
    ime_set_i = 1'b1; ime_clr_i = 1'b1; tick();
    ime_chk(1'b0, "R10 clear wins over set");

    // R7 R8 R9 two pending: bit 0 then bit 2
    set_ime();
    step_chk(1'b1, 16'h0040, "R7 lowest bit first");
    ime_chk(1'b0, "R9 ime cleared by dispatch");
    rd_chk(16'hFF0F, 8'hE4, 1'b1, "R9 only bit 0 cleared");
    step_chk(1'b0, 16'h0, "R6 ime off after dispatch");
    set_ime();
    step_chk(1'b1, 16'h0050, "R8 vector source 2");
    rd_chk(16'hFF0F, 8'hE0, 1'b1, "R9 bit 2 cleared");

    // R6 nothing pending
    set_ime();
    step_chk(1'b0, 16'h0, "R6 no dispatch with nothing pending");
    ime_chk(1'b1, "R6 ime kept when nothing pending");

    // R7 masking before priority
    wr(16'hFFFF, 8'h10);
    wr(16'hFF0F, 8'h1F);
    step_chk(1'b1, 16'h0060, "R7 masked low bits skipped");
    rd_chk(16'hFF0F, 8'hEF, 1'b1, "R9 only bit 4 cleared");

    // R8 walk every source
    for (int i = 0; i < 5; i++) begin
      wr(16'hFFFF, 8'(1 << i));
      wr(16'hFF0F, 8'(1 << i));
      set_ime();
      step_chk(1'b1, 16'h0040 + 16'(8 * i), "R8 vector walk");
      rd_chk(16'hFF0F, 8'hE0, 1'b1, "R9 walked flag cleared");
    end

    // R5 request ORed over a same-cycle flag write
    wr(16'hFF0F, 8'h11);
    bus_addr_i = 16'hFF0F; bus_wdata_i = 8'h04; bus_we_i = 1'b1; req_i = 5'b00010;
    tick();
    rd_chk(16'hFF0F, 8'hE6, 1'b1, "R5 request survives write");

    // R10 dispatch wins over a same-cycle set
    wr(16'hFFFF, 8'h02);
    set_ime();
    ime_set_i = 1'b1;
    step_chk(1'b1, 16'h0048, "R10 dispatch with set strobe");
    ime_chk(1'b0, "R10 dispatch wins over set");
    rd_chk(16'hFF0F, 8'hE4, 1'b1, "R9 bit 1 cleared, bit 2 kept");

    repeat (3) tick();
    if (q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL R8 scoreboard: actual %0d items left expected 0", q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule